// File: doc/BRIEF.md
# Two-Source Interrupt Arbiter

This block decides, at each instruction boundary of a small 8-bit controller core, whether the core must enter an interrupt service routine and to which entry address. It watches two sources: an external request line and the overflow pulse of an on-chip timer. Each source has its own pending latch and its own enable bit. An in-service flag makes sure that only one routine runs at a time.

When an entry is granted, the block asserts a take signal and a stack-push request in the same cycle. It drives the entry address, clears the granted source's pending latch and, for the external source, pulses an acknowledge back to the requester. A return strobe ends the service period. The block also keeps a second overflow flag that the core's test-and-branch instruction reads and clears. While a routine is in service it forces bit 11 of jump and call targets to zero, whatever memory bank is selected.

Top module: `dual_irq_arbiter`

## Requirements
- R1: After a synchronous reset, both pending latches, both enables, the in-service flag and the branch-test flag are 0. take_o, push_o and ack_o are 0 and vector_o is 0.
- R2: take_o is high in a cycle exactly when boundary_i is high, in_prog_o is low and at least one source has both its pending latch and its enable set. A take is never granted off a boundary.
- R3: While in_prog_o is high, take_o stays low whatever is pending.
- R4: When both sources are pending and enabled, the external source is granted.
- R5: An external grant drives vector_o = 0x003 and ack_o = 1 in the take cycle. On the next cycle the external pending latch is clear and in_prog_o is 1. When take_o is low, vector_o is 0 and ack_o is 0.
- R6: A timer grant drives vector_o = 0x007 with ack_o = 0. It clears the timer pending latch and sets in_prog_o on the next cycle.
- R7: A tmr_ovf_i pulse sets both the timer pending latch and tflag_o on the next cycle. The pending latch is cleared only by a timer grant, not by disabling. tflag_o is cleared only by tflag_test_i. If an overflow and a test arrive in the same cycle, the flag stays set.
- R8: push_o is high in exactly the cycles in which take_o is high.
- R9: a11_o equals bank_i while in_prog_o is 0, and is 0 while in_prog_o is 1.
- R10: reti_i clears in_prog_o on the next cycle, so pending work can be granted from the following boundary onward. A take in the same cycle as reti_i leaves in_prog_o set.
- R11: An enable set or clear strobe changes that source's behaviour from the next cycle on. If set and clear arrive in the same cycle, clear wins.
- R12: A request arriving in the same cycle as its own source's grant leaves that source pending again on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_req_i | input | 1 | External interrupt request, sets the external pending latch |
| tmr_ovf_i | input | 1 | One-cycle timer overflow pulse |
| ext_en_set_i | input | 1 | Enable the external source |
| ext_en_clr_i | input | 1 | Disable the external source |
| tmr_en_set_i | input | 1 | Enable the timer source |
| tmr_en_clr_i | input | 1 | Disable the timer source |
| boundary_i | input | 1 | Core is at an instruction boundary |
| reti_i | input | 1 | Return from the service routine |
| tflag_test_i | input | 1 | Test-and-branch on timer flag executed, clears the flag |
| bank_i | input | 1 | Selected program memory bank (address bit 11) |
| take_o | output | 1 | Enter an interrupt this cycle |
| push_o | output | 1 | Push PC and status onto the stack |
| vector_o | output | ADDR_W | Entry address of the granted source |
| ack_o | output | 1 | Acknowledge to the external requester |
| in_prog_o | output | 1 | A service routine is active |
| tflag_o | output | 1 | Timer flag read by the test-and-branch instruction |
| a11_o | output | 1 | Effective address bit 11 for jump and call targets |

## Verification
The hardest situations to reach are coincidences: a new request landing in the very cycle its own source is granted, and a return strobe meeting a granted entry. Others are an overflow and a flag test in one cycle, and an enable set and clear together. Directed sequences build these up one at a time from known state. A long run of seeded random strobes follows, with short bursts and a boundary about half the time, so that both sources stay pending across service periods. A cycle model in the bench, built from the requirements, predicts every output on every cycle.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int NSRC    = 2;
    localparam int SRC_EXT = 0;
    localparam int SRC_TMR = 1;

    typedef struct packed {
        logic take;
        logic [NSRC-1:0] grant;
    } irq_pick_t;

    typedef struct packed {
        logic in_prog;
        logic tflag;
    } irq_ctx_t;

    function automatic logic [1:0] next_latch(input logic cur,
                                              input logic set_c,
                                              input logic clr_c,
                                              input logic clr_wins);
        logic nxt;
        if (clr_wins) nxt = clr_c ? 1'b0 : (set_c ? 1'b1 : cur);
        else          nxt = set_c ? 1'b1 : (clr_c ? 1'b0 : cur);
        return {1'b0, nxt};
    endfunction

endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot
    import irq_arb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en_set,
    input  logic en_clr,
    input  logic req,
    input  logic granted,
    output logic pend_o,
    output logic en_o
);
    logic [1:0] en_nx;
    logic [1:0] pend_nx;

    always_comb begin
        en_nx   = next_latch(en_o, en_set, en_clr, 1'b1);
        pend_nx = next_latch(pend_o, req, granted, 1'b0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_o   <= 1'b0;
            pend_o <= 1'b0;
        end else begin
            en_o   <= en_nx[0];
            pend_o <= pend_nx[0];
        end
    end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_arb_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0] pend,
    input  logic [N-1:0] en,
    input  logic         in_prog,
    input  logic         boundary,
    output logic         take_o,
    output logic [N-1:0] grant_o
);
    logic found;

    always_comb begin
        found   = 1'b0;
        grant_o = '0;
        if (boundary && !in_prog) begin
            for (int i = 0; i < N; i++) begin
                if (!found && pend[i] && en[i]) begin
                    grant_o[i] = 1'b1;
                    found      = 1'b1;
                end
            end
        end
        take_o = found;
    end
endmodule

// File: rtl/irq_ctx.sv
module irq_ctx
    import irq_arb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic reti,
    input  logic ovf,
    input  logic test,
    input  logic bank,
    output logic in_prog_o,
    output logic tflag_o,
    output logic a11_o
);
    irq_ctx_t cur;
    irq_ctx_t nxt;
    logic [1:0] ip_nx;
    logic [1:0] tf_nx;

    always_comb begin
        ip_nx = next_latch(cur.in_prog, take, reti, 1'b0);
        tf_nx = next_latch(cur.tflag, ovf, test, 1'b0);
        nxt.in_prog = ip_nx[0];
        nxt.tflag   = tf_nx[0];
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign in_prog_o = cur.in_prog;
    assign tflag_o   = cur.tflag;
    assign a11_o     = cur.in_prog ? 1'b0 : bank;
endmodule

// File: rtl/dual_irq_arbiter.sv
module dual_irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int                ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] EXT_VEC = 12'h003,
    parameter logic [ADDR_W-1:0] TMR_VEC = 12'h007
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_req_i,
    input  logic              tmr_ovf_i,
    input  logic              ext_en_set_i,
    input  logic              ext_en_clr_i,
    input  logic              tmr_en_set_i,
    input  logic              tmr_en_clr_i,
    input  logic              boundary_i,
    input  logic              reti_i,
    input  logic              tflag_test_i,
    input  logic              bank_i,
    output logic              take_o,
    output logic              push_o,
    output logic [ADDR_W-1:0] vector_o,
    output logic              ack_o,
    output logic              in_prog_o,
    output logic              tflag_o,
    output logic              a11_o
);
    logic [NSRC-1:0] req, ens, enc, pend, en, grant;
    logic [ADDR_W-1:0] vec_tab [NSRC];
    irq_pick_t pick;

    assign req[SRC_EXT] = ext_req_i;
    assign req[SRC_TMR] = tmr_ovf_i;
    assign ens[SRC_EXT] = ext_en_set_i;
    assign ens[SRC_TMR] = tmr_en_set_i;
    assign enc[SRC_EXT] = ext_en_clr_i;
    assign enc[SRC_TMR] = tmr_en_clr_i;
    assign vec_tab[SRC_EXT] = EXT_VEC;
    assign vec_tab[SRC_TMR] = TMR_VEC;

    for (genvar g = 0; g < NSRC; g++) begin : g_slot
        irq_src_slot u_slot (
            .clk     (clk),
            .rst     (rst),
            .en_set  (ens[g]),
            .en_clr  (enc[g]),
            .req     (req[g]),
            .granted (grant[g]),
            .pend_o  (pend[g]),
            .en_o    (en[g])
        );
    end

    irq_pick #(.N(NSRC)) u_pick (
        .pend     (pend),
        .en       (en),
        .in_prog  (in_prog_o),
        .boundary (boundary_i),
        .take_o   (pick.take),
        .grant_o  (pick.grant)
    );

    assign grant = pick.grant;

    irq_ctx u_ctx (
        .clk       (clk),
        .rst       (rst),
        .take      (pick.take),
        .reti      (reti_i),
        .ovf       (tmr_ovf_i),
        .test      (tflag_test_i),
        .bank      (bank_i),
        .in_prog_o (in_prog_o),
        .tflag_o   (tflag_o),
        .a11_o     (a11_o)
    );

    always_comb begin
        vector_o = '0;
        for (int i = 0; i < NSRC; i++)
            if (grant[i]) vector_o = vec_tab[i];
    end

    assign take_o = pick.take;
    assign push_o = pick.take;
    assign ack_o  = grant[SRC_EXT];
endmodule

// File: rtl/irq_arb_checker.sv
module irq_arb_checker #(
    parameter int                ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] EXT_VEC = 12'h003,
    parameter logic [ADDR_W-1:0] TMR_VEC = 12'h007
) (
    input logic              clk,
    input logic              rst,
    input logic              boundary_i,
    input logic              reti_i,
    input logic              tflag_test_i,
    input logic              bank_i,
    input logic              take_o,
    input logic              push_o,
    input logic [ADDR_W-1:0] vector_o,
    input logic              ack_o,
    input logic              in_prog_o,
    input logic              tflag_o,
    input logic              a11_o
);
    p_on_boundary_r2: assert property (@(posedge clk) disable iff (rst)
        take_o |-> boundary_i);

    p_no_nest_r3: assert property (@(posedge clk) disable iff (rst)
        in_prog_o |-> !take_o);

    p_ext_vec_r5: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> (take_o && vector_o == EXT_VEC));

    p_tmr_noack_r6: assert property (@(posedge clk) disable iff (rst)
        (take_o && vector_o == TMR_VEC) |-> !ack_o);

    p_enter_r5: assert property (@(posedge clk) disable iff (rst)
        take_o |=> in_prog_o);

    p_flag_clear_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(tflag_o) |-> $past(tflag_test_i));

    p_push_r8: assert property (@(posedge clk) disable iff (rst)
        push_o |-> take_o);

    p_bank_r9: assert property (@(posedge clk) disable iff (rst)
        (!in_prog_o) |-> (a11_o == bank_i));

    p_reti_r10: assert property (@(posedge clk) disable iff (rst)
        (reti_i && !take_o) |=> !in_prog_o);
endmodule

bind dual_irq_arbiter irq_arb_checker #(
    .ADDR_W(ADDR_W), .EXT_VEC(EXT_VEC), .TMR_VEC(TMR_VEC)
) u_irq_arb_checker (
    .clk(clk), .rst(rst), .boundary_i(boundary_i), .reti_i(reti_i),
    .tflag_test_i(tflag_test_i), .bank_i(bank_i), .take_o(take_o),
    .push_o(push_o), .vector_o(vector_o), .ack_o(ack_o),
    .in_prog_o(in_prog_o), .tflag_o(tflag_o), .a11_o(a11_o)
);

// File: tb/test_dual_irq_arbiter.sv
module test_dual_irq_arbiter;
    logic clk = 1'b0;
    logic rst;
    logic ext_req, ovf, ext_set, ext_clr, tmr_set, tmr_clr;
    logic bnd, reti, test, bank;
    logic take, push, ack, inp, tflag, a11;
    logic [11:0] vec;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    // reference state
    logic m_ep, m_tp, m_ee, m_te, m_ip, m_tf;

    always #4 clk = ~clk;

    dual_irq_arbiter i_dual_irq_arbiter (
        .clk(clk), .rst(rst), .ext_req_i(ext_req), .tmr_ovf_i(ovf),
        .ext_en_set_i(ext_set), .ext_en_clr_i(ext_clr),
        .tmr_en_set_i(tmr_set), .tmr_en_clr_i(tmr_clr),
        .boundary_i(bnd), .reti_i(reti), .tflag_test_i(test), .bank_i(bank),
        .take_o(take), .push_o(push), .vector_o(vec), .ack_o(ack),
        .in_prog_o(inp), .tflag_o(tflag), .a11_o(a11)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
            summary();
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic exp_take();
        return bnd && !m_ip && ((m_ep && m_ee) || (m_tp && m_te));
    endfunction

    function automatic logic exp_ext();
        return exp_take() && m_ep && m_ee;
    endfunction

    task automatic idle();
        ext_req = 0; ovf = 0; ext_set = 0; ext_clr = 0; tmr_set = 0;
        tmr_clr = 0; bnd = 0; reti = 0; test = 0;
    endtask

    // compare all outputs, then advance one clock and the model
    task automatic step(input string tag);
        logic t, e;
        #1;
        t = exp_take();
        e = exp_ext();
        chk({tag, " R2 take"}, take, t);
        chk("R8 push", push, t);
        chk("R5 ack", ack, e);
        chk({tag, " R5/R6 vector"}, vec, !t ? 0 : (e ? 12'h003 : 12'h007));
        chk("R10 in_prog", inp, m_ip);
        chk("R7 tflag", tflag, m_tf);
        chk("R9 a11", a11, m_ip ? 0 : bank);
        @(posedge clk);
        m_ee = ext_clr ? 1'b0 : (ext_set ? 1'b1 : m_ee);
        m_te = tmr_clr ? 1'b0 : (tmr_set ? 1'b1 : m_te);
        m_ep = ext_req ? 1'b1 : ((t && e) ? 1'b0 : m_ep);
        m_tp = ovf ? 1'b1 : ((t && !e) ? 1'b0 : m_tp);
        m_ip = t ? 1'b1 : (reti ? 1'b0 : m_ip);
        m_tf = ovf ? 1'b1 : (test ? 1'b0 : m_tf);
        @(negedge clk);
        idle();
    endtask

    initial begin
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        idle();
        bank = 1;
        rst = 1;
        {m_ep, m_tp, m_ee, m_te, m_ip, m_tf} = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 take", take, 0);
        chk("R1 vector", vec, 0);
        chk("R1 in_prog", inp, 0);
        chk("R1 tflag", tflag, 0);
        rst = 0;
        @(negedge clk);

        // R11: enable and disable timing, clear wins
        ext_set = 1; ext_clr = 1; tmr_set = 1; step("R11");
        ext_req = 1; bnd = 1; step("R11 ext disabled");
        bnd = 1; step("R11 still off");
        chk("R11 no take", take, 0);
        // R4: both pending and enabled -> external
        ext_set = 1; ovf = 1; step("R7 ovf");
        chk("R7 tflag set", tflag, 1);
        bnd = 1; step("R4 prio");
        // R3: nothing while in service
        bnd = 1; step("R3 blocked");
        // R10: return, then timer granted at next boundary
        reti = 1; bnd = 1; step("R10 reti");
        bnd = 1; bank = 1; step("R6 timer");
        // R12: request with own grant
        reti = 1; step("R10");
        ext_req = 1; step("R12 pend");
        ext_req = 1; bnd = 1; step("R12 take+req");
        reti = 1; step("R10");
        bnd = 1; step("R12 re-take");
        // R7: disable keeps pending; test vs ovf
        reti = 1; tmr_clr = 1; ovf = 1; test = 1; step("R7 ovf+test");
        chk("R7 flag kept", tflag, 1);
        bnd = 1; step("R7 disabled");
        tmr_set = 1; test = 1; step("R7 test");
        bnd = 1; bank = 0; step("R7 pending survives");

        // random phase
        for (int k = 0; k < 4000; k++) begin
            ext_req = ($urandom % 8) == 0;
            ovf     = ($urandom % 8) == 0;
            ext_set = ($urandom % 6) == 0;
            ext_clr = ($urandom % 10) == 0;
            tmr_set = ($urandom % 6) == 0;
            tmr_clr = ($urandom % 10) == 0;
            bnd     = ($urandom % 2) == 0;
            reti    = ($urandom % 5) == 0;
            test    = ($urandom % 7) == 0;
            bank    = $urandom % 2;
            step("rand");
        end
        summary();
    end
endmodule